// File: doc/BRIEF.md
# Host-to-DSP DMA Byte Sequencer

This block is the host-facing half of a byte-wide host port working in host-to-DSP DMA mode. An external DMA controller delivers one byte per request/acknowledge handshake. An internal byte address counter steers each byte into a small bank of transmit byte registers. When the byte at the top address lands, the bank is complete. Once the DSP-side receive register is empty, the whole word moves into that register and a receive-full flag goes up.

The DSP side reads the receive register with a one-cycle strobe, and the read clears the flag. While the flag is set, two enables decide what the DSP side sees: an interrupt request, a DSP-side DMA request, or both. An initialize command resets the flags and loads the byte address counter from the mode bits. The same mode bits set the first byte address of every word, so the counter reloads from them each time a word is handed over. The mode value zero turns the DMA request off.

Top module: `hdma_h2d_seq`

## Requirements
- R1: After reset, hreq_o, rx_full_o, irq_o and dsp_dma_req_o are 0, tx_empty_o is 1, and no request is made until init_i has been seen.
- R2: A cycle with init_i high sets tx_empty_o to 1, clears rx_full_o and loads the byte address counter from mode_i. From the next cycle on, hreq_o is 1 if mode_i was nonzero.
- R3: A mode_i value of 0 keeps hreq_o low. A nonzero value m makes m the first byte address of each word, so a word holds NUM_BYTES-m+1 bytes (3, 2 or 1 with the default of 3 byte registers).
- R4: The byte written at address a (1..NUM_BYTES) goes to bits [(NUM_BYTES-a)*BYTE_W +: BYTE_W] of rx_data_o, so address 1 is the most significant byte. Bytes at addresses below the word's first address read as zero in the delivered word.
- R5: When hack_i is high in a cycle where hreq_o is high, hdata_i is latched into the addressed register. hreq_o is then low from the next cycle until the cycle after hack_i returns low.
- R6: From the cycle after the byte at address NUM_BYTES is latched, tx_empty_o is 0 and hreq_o stays low until the word has been handed over.
- R7: After hack_i is released on a complete word with rx_full_o at 0, the next cycle loads rx_data_o with the word, sets rx_full_o and tx_empty_o to 1 and reloads the counter from the mode_i value present then. hreq_o is high again from that cycle if that value is nonzero.
- R8: While a complete word waits and rx_full_o is 1, the sequencer stalls with hreq_o low and rx_data_o unchanged. The hand-over happens in the cycle after the flag has been seen low.
- R9: A cycle with rx_rd_i high clears rx_full_o from the next cycle on. Without a read or init_i, rx_full_o stays at 1.
- R10: irq_o is rx_full_o gated by irq_en_i, and dsp_dma_req_o is rx_full_o gated by dsp_dma_en_i. Both follow the flag whatever the handshake state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initialize command, one cycle |
| mode_i | input | 2 | Mode bits: 0 = no DMA, else first byte address |
| hack_i | input | 1 | DMA acknowledge / byte write strobe |
| hdata_i | input | 8 | Byte from the DMA controller |
| hreq_o | output | 1 | DMA request |
| tx_empty_o | output | 1 | Transmit byte bank still has free registers |
| rx_rd_i | input | 1 | DSP-side read strobe of the receive register |
| irq_en_i | input | 1 | Receive-full interrupt enable |
| dsp_dma_en_i | input | 1 | DSP-side DMA enable |
| rx_data_o | output | 24 | DSP-side receive data word |
| rx_full_o | output | 1 | Receive register holds an unread word |
| irq_o | output | 1 | Receive-full interrupt request |
| dsp_dma_req_o | output | 1 | DSP-side DMA transfer request |

## Verification
The assertions expect hack_i to rise only while hreq_o is high. They also expect hack_i to be low whenever init_i is pulsed, and rx_rd_i to be driven only as a one-cycle strobe. The bench's byte task follows this. It waits at the falling edge until hreq_o is set, then raises hack_i, holds it for a chosen number of cycles and drops it. The initialize and read tasks are only called with hack_i low. Mode bits are changed only outside a handshake, after a word's last byte has been released.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_REL  = 2'd2,
    ST_XFER = 2'd3
  } seq_st_e;
endpackage

// File: rtl/hdma_addr_ctr.sv
module hdma_addr_ctr #(
  parameter int unsigned NUM_BYTES = 3,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] start_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_BYTES);

  logic [ADDR_W-1:0] addr_q, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      start_q <= '0;
    end else if (load_i) begin
      addr_q  <= load_val_i;
      start_q <= load_val_i;
    end else if (inc_i) begin
      addr_q  <= addr_q + 1'b1;
    end
  end

  assign addr_o  = addr_q;
  assign start_o = start_q;
  assign last_o  = (addr_q == TOP_ADDR);
endmodule

// File: rtl/hdma_byte_bank.sv
module hdma_byte_bank #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 3,
  parameter int unsigned ADDR_W    = 2,
  localparam int unsigned WORD_W   = BYTE_W * NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [ADDR_W-1:0] start_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          byte_q <= '0;
      else if (clr_i)                       byte_q <= '0;
      else if (wr_i && addr_i == MY_ADDR)   byte_q <= data_i;
    end

    // bytes below the word's first address are not part of it
    assign word_o[(NUM_BYTES-1-i)*BYTE_W +: BYTE_W] =
      (MY_ADDR >= start_i) ? byte_q : '0;
  end
endmodule

// File: rtl/hdma_rx_reg.sv
module hdma_rx_reg #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              xfer_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      rx_full_o <= 1'b0;
    end else if (init_i) begin
      rx_full_o <= 1'b0;
    end else if (xfer_i) begin
      rx_data_o <= word_i;
      rx_full_o <= 1'b1;
    end else if (rd_i) begin
      rx_full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hdma_seq.sv
module hdma_seq #(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] mode_i,
  input  logic              hack_i,
  input  logic              rx_full_i,
  input  logic              last_i,
  output logic              hreq_o,
  output logic              tx_empty_o,
  output logic              wr_o,
  output logic              inc_o,
  output logic              ld_o,
  output logic              xfer_o,
  output logic              clr_o
);
  import hdma_pkg::*;

  seq_st_e st_q, st_d;
  logic    empty_q, empty_d;
  logic    dma_on, byte_fire, xfer_fire;

  assign dma_on    = (mode_i != '0);
  assign byte_fire = (st_q == ST_REQ) && hack_i && !init_i;
  assign xfer_fire = (st_q == ST_XFER) && !rx_full_i && !init_i;

  assign wr_o   = byte_fire;
  assign inc_o  = byte_fire && !last_i;
  assign ld_o   = init_i || xfer_fire;
  assign xfer_o = xfer_fire;
  assign clr_o  = init_i;

  always_comb begin
    st_d    = st_q;
    empty_d = empty_q;
    if (init_i) begin
      st_d    = dma_on ? ST_REQ : ST_IDLE;
      empty_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_REQ: if (hack_i) begin
          st_d = ST_REL;
          if (last_i) empty_d = 1'b0;
        end
        ST_REL: if (!hack_i) st_d = empty_q ? ST_REQ : ST_XFER;
        ST_XFER: if (!rx_full_i) begin
          st_d    = dma_on ? ST_REQ : ST_IDLE;
          empty_d = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      empty_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      empty_q <= empty_d;
    end
  end

  assign hreq_o     = (st_q == ST_REQ);
  assign tx_empty_o = empty_q;
endmodule

// File: rtl/hdma_h2d_seq.sv
module hdma_h2d_seq #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 3,
  localparam int unsigned ADDR_W   = $clog2(NUM_BYTES + 1),
  localparam int unsigned WORD_W   = BYTE_W * NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] mode_i,
  input  logic              hack_i,
  input  logic [BYTE_W-1:0] hdata_i,
  output logic              hreq_o,
  output logic              tx_empty_o,
  input  logic              rx_rd_i,
  input  logic              irq_en_i,
  input  logic              dsp_dma_en_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              irq_o,
  output logic              dsp_dma_req_o
);
  logic              wr, inc, ld, xfer, clr, last;
  logic [ADDR_W-1:0] addr, start;
  logic [WORD_W-1:0] word;

  hdma_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni, .init_i, .mode_i, .hack_i,
    .rx_full_i(rx_full_o), .last_i(last),
    .hreq_o, .tx_empty_o,
    .wr_o(wr), .inc_o(inc), .ld_o(ld), .xfer_o(xfer), .clr_o(clr)
  );

  hdma_addr_ctr #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_ctr (
    .clk_i, .rst_ni, .load_i(ld), .load_val_i(mode_i), .inc_i(inc),
    .addr_o(addr), .start_o(start), .last_o(last)
  );

  hdma_byte_bank #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_bank (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr), .addr_i(addr), .data_i(hdata_i),
    .start_i(start), .word_o(word)
  );

  hdma_rx_reg #(.WORD_W(WORD_W)) u_rx (
    .clk_i, .rst_ni, .init_i, .xfer_i(xfer), .rd_i(rx_rd_i), .word_i(word),
    .rx_data_o, .rx_full_o
  );

  assign irq_o         = rx_full_o & irq_en_i;
  assign dsp_dma_req_o = rx_full_o & dsp_dma_en_i;
endmodule

// File: rtl/hdma_h2d_chk.sv
module hdma_h2d_chk #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned WORD_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_i,
  input logic [ADDR_W-1:0] mode_i,
  input logic              hack_i,
  input logic              rx_rd_i,
  input logic              hreq_o,
  input logic              tx_empty_o,
  input logic [WORD_W-1:0] rx_data_o,
  input logic              rx_full_o,
  input logic              irq_o
);
  AST_INIT_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> tx_empty_o && !rx_full_o); // R2
  AST_MODE0_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i && mode_i == '0 |=> !hreq_o); // R3
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_o && hack_i && !init_i |=> !hreq_o); // R5
  AST_FULL_WORD_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_empty_o |-> !hreq_o); // R6
  AST_XFER_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> tx_empty_o); // R7
  AST_RX_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o && $past(rx_full_o) |-> $stable(rx_data_o)); // R8
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i && rx_full_o |=> !rx_full_o); // R9
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o && !rx_rd_i && !init_i |=> rx_full_o); // R9
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_full_o |-> !irq_o); // R10
endmodule

bind hdma_h2d_seq hdma_h2d_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chk_i (
  .clk_i, .rst_ni, .init_i, .mode_i, .hack_i, .rx_rd_i,
  .hreq_o, .tx_empty_o, .rx_data_o, .rx_full_o, .irq_o
);

// File: tb/hdma_h2d_seq_tb_top.sv
module hdma_h2d_seq_tb_top;
  localparam int NB = 3;
  localparam int BW = 8;
  localparam int WW = NB * BW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          init_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic          hack_i = 1'b0;
  logic [BW-1:0] hdata_i = '0;
  logic          hreq_o, tx_empty_o;
  logic          rx_rd_i = 1'b0;
  logic          irq_en_i = 1'b0;
  logic          dsp_dma_en_i = 1'b0;
  logic [WW-1:0] rx_data_o;
  logic          rx_full_o, irq_o, dsp_dma_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [WW-1:0] exp_q[$];
  logic [WW-1:0] last_word = '0;
  bit prev_full = 0;

  always #2 clk_i = ~clk_i;

  hdma_h2d_seq dut_i (
    .clk_i, .rst_ni, .init_i, .mode_i, .hack_i, .hdata_i, .hreq_o, .tx_empty_o,
    .rx_rd_i, .irq_en_i, .dsp_dma_en_i, .rx_data_o, .rx_full_o, .irq_o,
    .dsp_dma_req_o
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: each new receive word is compared with the scoreboard head
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rx_full_o && !prev_full) begin
        if (exp_q.size() == 0) begin
          check(0, "R4 unexpected word", 32'(rx_data_o), 32'hX);
        end else begin
          logic [WW-1:0] e;
          e = exp_q.pop_front();
          check(rx_data_o == e, "R4/R7 word", 32'(rx_data_o), 32'(e));
          last_word = e;
        end
      end
      prev_full = rx_full_o;
    end
  end

  task automatic do_init(input logic [1:0] m);
    mode_i = m; init_i = 1'b1;
    @(negedge clk_i);
    init_i = 1'b0;
  endtask

  task automatic do_read();
    rx_rd_i = 1'b1;
    @(negedge clk_i);
    rx_rd_i = 1'b0;
  endtask

  task automatic send_byte(input logic [BW-1:0] b, input int hold);
    while (!hreq_o) @(negedge clk_i);
    hack_i = 1'b1; hdata_i = b;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk_i);
      check(!hreq_o, "R5 hreq low while hack held", 32'(hreq_o), 0);
    end
    hack_i = 1'b0;
  endtask

  // driver: pushes the expected word, then feeds its bytes
  task automatic send_word(input int start, input logic [BW-1:0] seed, input int hold);
    logic [WW-1:0] e;
    e = '0;
    for (int a = start; a <= NB; a++) e[(NB-a)*BW +: BW] = seed + BW'(a);
    exp_q.push_back(e);
    for (int a = start; a <= NB; a++) send_byte(seed + BW'(a), hold);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(!hreq_o && !rx_full_o && tx_empty_o && !irq_o && !dsp_dma_req_o,
          "R1 reset outputs", {hreq_o, rx_full_o, tx_empty_o, irq_o}, 4'b0010);
    repeat (3) @(negedge clk_i);
    check(!hreq_o, "R1 no request before init", 32'(hreq_o), 0);

    // R3 mode 0 keeps request off
    do_init(2'd0);
    repeat (4) @(negedge clk_i);
    check(!hreq_o, "R3 mode 0 no request", 32'(hreq_o), 0);

    // R2 init with mode 1
    do_init(2'd1);
    check(hreq_o && tx_empty_o && !rx_full_o, "R2 init request",
          {hreq_o, tx_empty_o, rx_full_o}, 3'b110);

    // 3-byte word, long hack hold on each byte (R4, R5)
    send_word(1, 8'h10, 3);
    @(negedge clk_i);
    // R6: at the cycle after release, word waits in the bank
    check(!tx_empty_o && !hreq_o, "R6 complete word pending",
          {tx_empty_o, hreq_o}, 2'b00);
    @(negedge clk_i);
    check(rx_full_o && tx_empty_o && hreq_o, "R7 hand-over",
          {rx_full_o, tx_empty_o, hreq_o}, 3'b111);

    // R10 gating
    irq_en_i = 1'b0; dsp_dma_en_i = 1'b0; #1;
    check(!irq_o && !dsp_dma_req_o, "R10 gated off", {irq_o, dsp_dma_req_o}, 0);
    irq_en_i = 1'b1; #1;
    check(irq_o && !dsp_dma_req_o, "R10 irq only", {irq_o, dsp_dma_req_o}, 2'b10);
    dsp_dma_en_i = 1'b1; irq_en_i = 1'b0; #1;
    check(!irq_o && dsp_dma_req_o, "R10 dsp dma only", {irq_o, dsp_dma_req_o}, 2'b01);
    irq_en_i = 1'b1;
    @(negedge clk_i);

    // R8: second word with receive still full stalls
    send_word(1, 8'h40, 1);
    repeat (5) @(negedge clk_i);
    check(!hreq_o && !tx_empty_o && rx_full_o, "R8 stall",
          {hreq_o, tx_empty_o, rx_full_o}, 3'b001);
    check(rx_data_o == 24'h111213, "R8 rx data kept", 32'(rx_data_o), 32'h111213);
    check(irq_o, "R10 irq during stall", 32'(irq_o), 1);
    do_read();
    check(!rx_full_o && !irq_o, "R9 read clears", {rx_full_o, irq_o}, 0);
    @(negedge clk_i);
    check(rx_full_o && hreq_o, "R8 released after read", {rx_full_o, hreq_o}, 2'b11);
    do_read();
    repeat (3) @(negedge clk_i);
    check(!rx_full_o, "R9 flag stays clear", 32'(rx_full_o), 0);

    // R3/R4: mode 2 gives 2-byte word, stale top byte masked
    do_init(2'd2);
    send_word(2, 8'h60, 1);
    repeat (3) @(negedge clk_i);
    check(rx_full_o, "R3 two-byte word delivered", 32'(rx_full_o), 1);
    repeat (4) @(negedge clk_i);
    check(rx_full_o, "R9 flag held without read", 32'(rx_full_o), 1);
    do_read();

    // R7: reload uses mode present at hand-over
    send_word(2, 8'h70, 1);
    mode_i = 2'd3;
    repeat (3) @(negedge clk_i);
    do_read();
    send_word(3, 8'h80, 2);
    repeat (3) @(negedge clk_i);
    check(rx_full_o, "R7 one-byte word after reload", 32'(rx_full_o), 1);

    // R2: init while full clears flag
    do_init(2'd1);
    check(!rx_full_o && tx_empty_o, "R2 init clears full", {rx_full_o, tx_empty_o}, 2'b01);

    // R7: mode 0 at hand-over stops further requests
    send_word(1, 8'hA0, 1);
    mode_i = 2'd0;
    repeat (3) @(negedge clk_i);
    check(rx_full_o && !hreq_o, "R7 mode 0 at reload", {rx_full_o, hreq_o}, 2'b10);
    repeat (2) @(negedge clk_i);
    check(exp_q.size() == 0, "R4 all words seen", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule